// File: doc/BRIEF.md
# Drawing-engine register write queue

This block sits between a host register bus and a 2D drawing engine. Each host write carries a data word and a dword register offset. Offsets below a fixed boundary name control registers that must act at once, so they skip the queue and come out on a direct port one cycle later. Offsets at or above the boundary name drawing registers. Those writes enter a first-in first-out command queue, and the engine pulls entries from it one per cycle while it signals ready.

Software learns how much room is left from a status word that holds a thermometer code with one bit set per occupied entry. The usual poll shifts a single bit right by the number of entries wanted and waits while the status is greater than that value. A busy flag covers both queued work and an engine that is still drawing. A write that arrives when the queue is full is lost and sets a sticky overflow error, which software clears with an acknowledge pulse. Turning the engine enable off empties the queue and drops the busy flag. Turning it on again brings the engine back in a clean state.

Top module: `engine_write_front`

## Requirements
- R1: After a synchronous reset, the status word is 0 and busy, overflow error, queue-valid and direct-valid all read 0.
- R2: A write whose offset is below QUEUE_BASE (0x40 by default) appears on the direct port, with its offset and data, in the cycle after the write, and the status word does not change. The direct port works whether or not the engine is enabled. Offset 0x40 itself goes into the queue.
- R3: With k entries occupied, the status word reads (1<<k)-1. Bit i is set exactly when more than i entries are held.
- R4: With DEPTH=16, the poll "wait while status > (0x8000>>n)" lets software proceed only when at least n entries are free, for every n from 1 to 16. For n=16 it proceeds exactly when the queue is empty.
- R5: A queued write that arrives while all DEPTH entries are occupied is discarded, the contents already held stay as they were, and the overflow error becomes 1.
- R6: The overflow error stays 1 until an acknowledge pulse clears it. If an acknowledge and a new overflow happen in the same cycle, the error stays 1.
- R7: Entries leave in arrival order, one per clock edge, while the engine is enabled and signals ready. While ready is low, nothing leaves. Queue-valid is 1 exactly when the status word is nonzero.
- R8: Busy reads 1 in the cycle after an edge at which the queue holds entries or the engine reports activity, and reads 0 otherwise.
- R9: While the engine enable is low, the queue is emptied (status 0, queue-valid 0), busy is 0, and queued writes are discarded without raising the overflow error. After enable returns, new writes are delivered from a clean queue.
- R10: A push and a pop at the same edge leave the occupancy unchanged, and the new entry becomes the head once the old head has left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe |
| wr_ofs | input | OFS_W | Dword register offset of the write |
| wr_data | input | DATA_W | Write data |
| eng_en | input | 1 | Engine enable; low flushes the queue |
| err_ack | input | 1 | Write-one acknowledge for the overflow error |
| eng_active | input | 1 | Engine reports drawing in progress |
| eng_ready | input | 1 | Engine accepts the queue head this cycle |
| dir_valid | output | 1 | Direct (non-queued) write valid, one cycle |
| dir_ofs | output | OFS_W | Offset of the direct write |
| dir_data | output | DATA_W | Data of the direct write |
| q_valid | output | 1 | Queue head is valid |
| q_ofs | output | OFS_W | Offset of the queue head |
| q_data | output | DATA_W | Data of the queue head |
| fifo_level | output | DEPTH | Thermometer occupancy status |
| busy | output | 1 | Queue non-empty or engine active |
| ovf_err | output | 1 | Sticky overflow error |

## Verification
The bench fills the queue one entry at a time and, at every occupancy, compares the status word with the closed form and tries the software poll for all sixteen request sizes. An off-by-one in the thermometer would let software write into a full queue. It tests the boundary offsets 0x3F and 0x40, because a comparator that is off by one sends a control write into the queue or a drawing write past it. It pushes into a full queue while an acknowledge arrives in the same cycle; a design that gives priority to the clear would lose the error. It drains the queue and checks the order of the entries, pushes and pops in the same cycle, and flushes by dropping the enable. A design that gets these wrong reorders commands, miscounts, or keeps busy high with an engine that is off.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  // What happens to one host write
  typedef enum logic [2:0] {
    WK_IDLE,    // no write this cycle
    WK_DIRECT,  // below the queue boundary: forwarded at once
    WK_QUEUE,   // accepted into the command queue
    WK_FULL,    // queue full: discarded, error raised
    WK_OFF      // engine disabled: discarded silently
  } wr_kind_e;
endpackage

// File: rtl/cmdq_classify.sv
module cmdq_classify
  import cmdq_pkg::*;
#(
  parameter int OFS_W      = 8,
  parameter int QUEUE_BASE = 64
) (
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic             eng_en,
  input  logic             full,
  output wr_kind_e         kind
);
  localparam logic [OFS_W-1:0] BASE = OFS_W'(QUEUE_BASE);

  always_comb begin
    if (!wr_en)             kind = WK_IDLE;
    else if (wr_ofs < BASE) kind = WK_DIRECT;
    else if (!eng_en)       kind = WK_OFF;
    else if (full)          kind = WK_FULL;
    else                    kind = WK_QUEUE;
  end
endmodule

// File: rtl/cmdq_store.sv
module cmdq_store #(
  parameter int WIDTH = 40,
  parameter int DEPTH = 16,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [WIDTH-1:0] rdata
);
  // Plain array, no reset: maps onto distributed RAM with a show-ahead read
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];
endmodule

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl #(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eng_en,
  input  logic             push,
  input  logic             eng_ready,
  input  logic             eng_active,
  output logic             full,
  output logic             q_valid,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [DEPTH-1:0] level,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [DEPTH-1:0] lvl_nxt;
  logic             pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign pop     = eng_en && eng_ready && (cnt_q != '0);
  assign cnt_nxt = cnt_q + CNT_W'(push) - CNT_W'(pop);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign q_valid = (cnt_q != '0);

  // Thermometer: bit i set while more than i entries are held
  for (genvar g = 0; g < DEPTH; g++) begin : g_thermo
    assign lvl_nxt[g] = (cnt_nxt > CNT_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst || !eng_en) begin
      cnt_q  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      busy   <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      level <= lvl_nxt;
      busy  <= (cnt_nxt != '0) || eng_active;
    end
  end
endmodule

// File: rtl/engine_write_front.sv
module engine_write_front
  import cmdq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int OFS_W      = 8,
  parameter int DEPTH      = 16,
  parameter int QUEUE_BASE = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              eng_en,
  input  logic              err_ack,
  input  logic              eng_active,
  input  logic              eng_ready,
  output logic              dir_valid,
  output logic [OFS_W-1:0]  dir_ofs,
  output logic [DATA_W-1:0] dir_data,
  output logic              q_valid,
  output logic [OFS_W-1:0]  q_ofs,
  output logic [DATA_W-1:0] q_data,
  output logic [DEPTH-1:0]  fifo_level,
  output logic              busy,
  output logic              ovf_err
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = OFS_W + DATA_W;

  wr_kind_e         kind;
  logic             full;
  logic             push;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [ENT_W-1:0] head;

  cmdq_classify #(.OFS_W(OFS_W), .QUEUE_BASE(QUEUE_BASE)) u_classify (
    .wr_en (wr_en),
    .wr_ofs(wr_ofs),
    .eng_en(eng_en),
    .full  (full),
    .kind  (kind)
  );

  assign push = (kind == WK_QUEUE);

  cmdq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .eng_en    (eng_en),
    .push      (push),
    .eng_ready (eng_ready),
    .eng_active(eng_active),
    .full      (full),
    .q_valid   (q_valid),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .level     (fifo_level),
    .busy      (busy)
  );

  cmdq_store #(.WIDTH(ENT_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk   (clk),
    .we    (push),
    .wr_ptr(wr_ptr),
    .wdata ({wr_ofs, wr_data}),
    .rd_ptr(rd_ptr),
    .rdata (head)
  );

  assign q_ofs  = head[ENT_W-1:DATA_W];
  assign q_data = head[DATA_W-1:0];

  // Direct path: registered one-cycle pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_valid <= 1'b0;
      dir_ofs   <= '0;
      dir_data  <= '0;
    end else begin
      dir_valid <= (kind == WK_DIRECT);
      if (kind == WK_DIRECT) begin
        dir_ofs  <= wr_ofs;
        dir_data <= wr_data;
      end
    end
  end

  // Sticky overflow; a new overflow wins over a simultaneous acknowledge
  always_ff @(posedge clk) begin
    if (rst)                  ovf_err <= 1'b0;
    else if (kind == WK_FULL) ovf_err <= 1'b1;
    else if (err_ack)         ovf_err <= 1'b0;
  end
endmodule

// File: rtl/engine_write_front_chk.sv
module engine_write_front_chk #(
  parameter int DATA_W     = 32,
  parameter int OFS_W      = 8,
  parameter int DEPTH      = 16,
  parameter int QUEUE_BASE = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [OFS_W-1:0]  wr_ofs,
  input logic [DATA_W-1:0] wr_data,
  input logic              eng_en,
  input logic              err_ack,
  input logic              dir_valid,
  input logic [DATA_W-1:0] dir_data,
  input logic              q_valid,
  input logic [DEPTH-1:0]  fifo_level,
  input logic              busy,
  input logic              ovf_err
);
  localparam logic [OFS_W-1:0] BASE = OFS_W'(QUEUE_BASE);

  logic drop_full;
  assign drop_full = wr_en && (wr_ofs >= BASE) && eng_en && (&fifo_level);

  a_r2_bypass: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_ofs < BASE) |=> (dir_valid && dir_data == $past(wr_data)));

  a_r3_thermometer: assert property (@(posedge clk) disable iff (rst)
    ((fifo_level + 1'b1) & fifo_level) == '0);

  a_r5_drop_flags: assert property (@(posedge clk) disable iff (rst)
    drop_full |=> ovf_err);

  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_err && !err_ack) |=> ovf_err);

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (err_ack && !drop_full) |=> !ovf_err);

  a_r7_valid_level: assert property (@(posedge clk) disable iff (rst)
    q_valid == (fifo_level != '0));

  a_r9_flush: assert property (@(posedge clk) disable iff (rst)
    !eng_en |=> (fifo_level == '0 && !busy && !q_valid));
endmodule

bind engine_write_front engine_write_front_chk #(
  .DATA_W(DATA_W), .OFS_W(OFS_W), .DEPTH(DEPTH), .QUEUE_BASE(QUEUE_BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_ofs    (wr_ofs),
  .wr_data   (wr_data),
  .eng_en    (eng_en),
  .err_ack   (err_ack),
  .dir_valid (dir_valid),
  .dir_data  (dir_data),
  .q_valid   (q_valid),
  .fifo_level(fifo_level),
  .busy      (busy),
  .ovf_err   (ovf_err)
);

// File: tb/test_engine_write_front.sv
module test_engine_write_front;
  localparam int DW = 32, OW = 8, D = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [OW-1:0] wr_ofs = '0;
  logic [DW-1:0] wr_data = '0;
  logic          eng_en = 1'b0, err_ack = 1'b0, eng_active = 1'b0, eng_ready = 1'b0;
  logic          dir_valid, q_valid, busy, ovf_err;
  logic [OW-1:0] dir_ofs, q_ofs;
  logic [DW-1:0] dir_data, q_data;
  logic [D-1:0]  fifo_level;

  int checks = 0, errors = 0;
  logic [OW-1:0] m_ofs [64];
  logic [DW-1:0] m_dat [64];
  int m_head = 0, m_tail = 0;

  always #5 clk = ~clk;

  engine_write_front i_engine_write_front (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data),
    .eng_en(eng_en), .err_ack(err_ack), .eng_active(eng_active), .eng_ready(eng_ready),
    .dir_valid(dir_valid), .dir_ofs(dir_ofs), .dir_data(dir_data),
    .q_valid(q_valid), .q_ofs(q_ofs), .q_data(q_data),
    .fifo_level(fifo_level), .busy(busy), .ovf_err(ovf_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // One write, driven after a falling edge; returns one falling edge later
  task automatic wr(input logic [OW-1:0] o, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_ofs = o; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push_model(input logic [OW-1:0] o, input logic [DW-1:0] d);
    m_ofs[m_tail] = o; m_dat[m_tail] = d; m_tail++;
  endtask

  function automatic logic [D-1:0] thermo(input int k);
    return D'((64'd1 << k) - 64'd1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0; eng_en = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 level", fifo_level, 0);
    chk("R1 busy", busy, 0);
    chk("R1 ovf", ovf_err, 0);
    chk("R1 q_valid", q_valid, 0);
    chk("R1 dir_valid", dir_valid, 0);

    // R2 boundary: 0x3F direct, 0x40 queued
    wr(8'h3F, 32'hA5A5_0001);
    chk("R2 dir_valid", dir_valid, 1);
    chk("R2 dir_ofs", dir_ofs, 8'h3F);
    chk("R2 dir_data", dir_data, 32'hA5A5_0001);
    chk("R2 level unchanged", fifo_level, 0);
    @(negedge clk);
    chk("R2 pulse ends", dir_valid, 0);
    wr(8'h40, 32'hB000_0040);
    push_model(8'h40, 32'hB000_0040);
    chk("R2 0x40 queued", fifo_level, thermo(1));
    chk("R2 0x40 not direct", dir_valid, 0);

    // R3/R4 fill sweep
    for (int k = 2; k <= D; k++) begin
      wr(OW'(8'h40 + k), 32'hC0DE_0000 + k);
      push_model(OW'(8'h40 + k), 32'hC0DE_0000 + k);
      chk("R3 level", fifo_level, thermo(k));
      chk("R8 busy while queued", busy, 1);
      for (int n = 1; n <= 16; n++) begin
        logic waits;
        waits = {16'h0, fifo_level} > (32'h8000 >> n);
        if (!waits) chk("R4 proceed implies room", (D - k) >= n, 1);
        if (n == 16) chk("R4 full-empty poll", waits, 1);
      end
    end
    chk("R7 valid when full", q_valid, 1);

    // R5 overflow, R6 sticky / set-wins / clear; R7 no pop while not ready
    wr(8'h41, 32'hDEAD_BEEF);
    chk("R5 ovf set", ovf_err, 1);
    chk("R5 level kept", fifo_level, thermo(D));
    repeat (3) @(negedge clk);
    chk("R6 sticky", ovf_err, 1);
    chk("R7 no pop without ready", fifo_level, thermo(D));
    err_ack = 1'b1;
    wr(8'h42, 32'hDEAD_0002);
    err_ack = 1'b0;
    chk("R6 set wins over ack", ovf_err, 1);
    err_ack = 1'b1;
    @(negedge clk);
    err_ack = 1'b0;
    chk("R6 ack clears", ovf_err, 0);
    chk("R5 head unchanged", q_data, m_dat[m_head]);

    // R7 drain in order
    eng_ready = 1'b1;
    for (int i = 0; i < D; i++) begin
      chk("R7 valid", q_valid, 1);
      chk("R7 order data", q_data, m_dat[m_head]);
      chk("R7 order ofs", q_ofs, m_ofs[m_head]);
      chk("R3 level draining", fifo_level, thermo(D - i));
      m_head++;
      @(negedge clk);
    end
    eng_ready = 1'b0;
    chk("R7 empty", q_valid, 0);
    chk("R3 level empty", fifo_level, 0);
    chk("R8 idle", busy, 0);

    // R8 engine activity alone
    eng_active = 1'b1;
    @(negedge clk);
    chk("R8 busy from engine", busy, 1);
    eng_active = 1'b0;
    @(negedge clk);
    chk("R8 busy clears", busy, 0);

    // R10 push and pop at the same edge
    wr(8'h50, 32'h1111_0001);
    chk("R10 one entry", fifo_level, thermo(1));
    eng_ready = 1'b1;
    wr(8'h51, 32'h1111_0002);
    chk("R10 occupancy held", fifo_level, thermo(1));
    chk("R10 new head", q_data, 32'h1111_0002);
    @(negedge clk);
    eng_ready = 1'b0;
    chk("R10 drained", fifo_level, 0);

    // R9 disable flushes
    wr(8'h60, 32'h2222_0001);
    wr(8'h61, 32'h2222_0002);
    wr(8'h62, 32'h2222_0003);
    eng_active = 1'b1;
    @(negedge clk);
    chk("R9 pre level", fifo_level, thermo(3));
    eng_en = 1'b0;
    @(negedge clk);
    chk("R9 flushed", fifo_level, 0);
    chk("R9 busy low", busy, 0);
    chk("R9 q_valid low", q_valid, 0);
    wr(8'h63, 32'h2222_0004);
    chk("R9 discarded", fifo_level, 0);
    chk("R9 no ovf", ovf_err, 0);
    wr(8'h10, 32'h3333_0001);
    chk("R2 direct while disabled", dir_data, 32'h3333_0001);
    chk("R2 direct valid while disabled", dir_valid, 1);
    eng_en = 1'b1; eng_active = 1'b0;
    @(negedge clk);
    chk("R9 clean after enable", fifo_level, 0);
    wr(8'h70, 32'h4444_0001);
    chk("R9 fresh level", fifo_level, thermo(1));
    chk("R9 fresh head", q_data, 32'h4444_0001);
    chk("R9 fresh ofs", q_ofs, 8'h70);

    summary();
  end
endmodule